// File: doc/BRIEF.md
# SDRAM Command Timing Controller

This block sits between a simple request port and a two-bank synchronous DRAM with a 16-bit data bus. It turns each single-word read or write request (bank, row, column, data, byte enables) into the command sequence the memory needs. That sequence is one or more of: precharge, bank activate, and the column read or write. The block drives the chip select, row strobe, column strobe, write enable, bank address, address and data-mask pins from registers. It counts every row, precharge, write-recovery and refresh interval in clock cycles. Read data is captured from the bus CAS-latency cycles after the read command and handed back in request order.

After reset the controller closes all banks and programs the mode register for single-word bursts, sequential order and the configured CAS latency. It then serves requests with an open-row policy and one row register per bank. A free-running interval timer raises a refresh request every `REF_CYC` clocks. Refresh takes priority over user traffic: open rows are closed with a precharge-all, and once every bank is idle long enough an auto refresh is issued. Timing defaults match a 133 MHz, CL=3 speed grade. For the 83 MHz, CL=2 grade, set the parameters to CL=2 and tRCD/tRAS/tRC/tRP = 2/5/7/2.

Top module: `sdram_ctl`

## Requirements
- R1: While reset is low the pins carry no-operation, `ready_o`, `rvalid_o` and `sd_dq_oe_o` are 0. The first command after reset is a precharge with A10 high, and the second is the mode register set.
- R2: Commands on {cs_n,ras_n,cas_n,we_n} use the following codes: mode set 0000, activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, no-operation 0111. No other code appears. The mode word has burst length 1 (A2..A0 = 000), sequential order (A3 = 0), CAS latency in A6..A4, and all other bits 0. It is issued only with all banks closed.
- R3: At least `T_MRD` (2) cycles separate a mode register set from the next command.
- R4: A read or write to a bank comes at least `T_RCD` cycles after that bank's activate.
- R5: A bank is precharged no sooner than `T_RAS` cycles after its activate. Two activates of the same bank are at least `T_RC` cycles apart.
- R6: An activate comes at least `T_RP` cycles after that bank's precharge. No command follows an auto refresh within `T_RC` cycles.
- R7: Write data and the output enable appear in the same cycle as the write command and in no other cycle. `sd_dqm_o` is the inverse of the byte enables, so a disabled byte is left unchanged in memory.
- R8: A precharge of a bank comes at least `T_WR` (2) cycles after a write to it, and an activate at least `T_DAL` (4) cycles after that write.
- R9: `rvalid_o` pulses exactly `CAS_LAT`+1 cycles after a read command is on the pins. It carries the word sampled from `sd_dq_i` CAS_LAT cycles after that command, which is the last data written to that address.
- R10: Open-row policy. A request to the open row of its bank issues only the column command. Another row first gets a single-bank precharge with A10 low, then an activate. An activate never targets an open bank, and reads and writes never target a closed bank. A10 is low on every read and write.
- R11: An auto refresh is issued only with every bank closed and at least `T_RP` after the last precharge. Consecutive refreshes are no more than `REF_CYC`+40 cycles apart.
- R12: Exactly one request is taken per cycle with `req_i` and `ready_o` both high. Read results return in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request valid, held until accepted |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BA_W | Bank of the request |
| req_row_i | input | ROW_W | Row of the request |
| req_col_i | input | COL_W | Column of the request |
| req_wdata_i | input | DQ_W | Write data |
| req_be_i | input | DQ_W/8 | Byte enables for a write |
| ready_o | output | 1 | Request accepted this cycle |
| rdata_o | output | DQ_W | Read data |
| rvalid_o | output | 1 | Read data valid |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | BA_W | Bank address |
| sd_addr_o | output | ROW_W | Row/column address, A10 = precharge-all / auto-precharge flag |
| sd_dqm_o | output | DQ_W/8 | Byte data mask |
| sd_dq_o | output | DQ_W | Data driven to memory |
| sd_dq_oe_o | output | 1 | Data output enable |
| sd_dq_i | input | DQ_W | Data from memory |

## Verification
Runs of hits to one open row show that back-to-back column commands need no activate and that partial byte enables merge correctly. Alternating rows in the same bank forces a precharge and activate on every request, which stresses tRAS, tRC, tRP and write recovery. Requests alternating between the two banks show that each bank's timers run independently. A long pseudo-random mix with a short refresh interval lands refreshes on top of open rows and pending writes. That mix separates the close-then-refresh path from user traffic, and it uses the extreme row 2047 and column 255.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_PALL,
    ST_MRS,
    ST_RUN
  } ctl_state_e;
endpackage

// File: rtl/sdc_bank.sv
module sdc_bank #(
  parameter int ROW_W = 11,
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RC  = 9,
  parameter int T_RP  = 3,
  parameter int T_WR  = 2,
  parameter int T_DAL = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             wr_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rw_ok_o,
  output logic             pre_ok_o,
  output logic             act_ok_o
);
  localparam int MAXT = (T_RC > T_DAL) ? T_RC : T_DAL;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] SAT   = CW'(MAXT);
  localparam logic [CW-1:0] C_RCD = CW'(T_RCD);
  localparam logic [CW-1:0] C_RAS = CW'(T_RAS);
  localparam logic [CW-1:0] C_RC  = CW'(T_RC);
  localparam logic [CW-1:0] C_RP  = CW'(T_RP);
  localparam logic [CW-1:0] C_WR  = CW'(T_WR);
  localparam logic [CW-1:0] C_DAL = CW'(T_DAL);

  // cycles since the last activate / precharge / write of this bank
  logic [CW-1:0] act_cnt, pre_cnt, wr_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o  <= 1'b0;
      row_o   <= '0;
      act_cnt <= SAT;
      pre_cnt <= SAT;
      wr_cnt  <= SAT;
    end else begin
      if (act_i) begin
        open_o  <= 1'b1;
        row_o   <= row_i;
        act_cnt <= CW'(1);
      end else if (act_cnt != SAT) begin
        act_cnt <= act_cnt + 1'b1;
      end
      if (pre_i) begin
        open_o  <= 1'b0;
        pre_cnt <= CW'(1);
      end else if (pre_cnt != SAT) begin
        pre_cnt <= pre_cnt + 1'b1;
      end
      if (wr_i) wr_cnt <= CW'(1);
      else if (wr_cnt != SAT) wr_cnt <= wr_cnt + 1'b1;
    end
  end

  assign rw_ok_o  = open_o && (act_cnt >= C_RCD);
  assign pre_ok_o = open_o && (act_cnt >= C_RAS) && (wr_cnt >= C_WR);
  assign act_ok_o = !open_o && (pre_cnt >= C_RP) && (act_cnt >= C_RC) && (wr_cnt >= C_DAL);
endmodule

// File: rtl/sdc_ref_timer.sv
module sdc_ref_timer #(
  parameter int REF_CYC = 2083
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int RW = $clog2(REF_CYC);
  localparam logic [RW-1:0] RELOAD = RW'(REF_CYC - 1);

  logic [RW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt    <= RELOAD;
      pend_o <= 1'b0;
    end else begin
      if (cnt == '0) cnt <= RELOAD;
      else           cnt <= cnt - 1'b1;
      if (cnt == '0)  pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sdc_rd_pipe.sv
module sdc_rd_pipe #(
  parameter int CAS_LAT = 3,
  parameter int DQ_W    = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_on_pins_i,
  input  logic [DQ_W-1:0] dq_i,
  output logic [DQ_W-1:0] rdata_o,
  output logic            rvalid_o
);
  logic [CAS_LAT-1:0] pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe     <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      pipe     <= {pipe[CAS_LAT-2:0], rd_on_pins_i};
      rvalid_o <= pipe[CAS_LAT-1];
      if (pipe[CAS_LAT-1]) rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/sdram_ctl.sv
module sdram_ctl
  import sdc_pkg::*;
#(
  parameter int ROW_W   = 11,
  parameter int COL_W   = 8,
  parameter int BA_W    = 1,
  parameter int DQ_W    = 16,
  parameter int CAS_LAT = 3,
  parameter int T_RCD   = 3,
  parameter int T_RAS   = 6,
  parameter int T_RC    = 9,
  parameter int T_RP    = 3,
  parameter int T_MRD   = 2,
  parameter int T_WR    = 2,
  parameter int T_DAL   = 4,
  parameter int REF_CYC = 2083
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [BA_W-1:0]   req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [DQ_W-1:0]   req_wdata_i,
  input  logic [DQ_W/8-1:0] req_be_i,
  output logic              ready_o,
  output logic [DQ_W-1:0]   rdata_o,
  output logic              rvalid_o,
  output logic              sd_cs_n_o,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic [BA_W-1:0]   sd_ba_o,
  output logic [ROW_W-1:0]  sd_addr_o,
  output logic [DQ_W/8-1:0] sd_dqm_o,
  output logic [DQ_W-1:0]   sd_dq_o,
  output logic              sd_dq_oe_o,
  input  logic [DQ_W-1:0]   sd_dq_i
);
  localparam int NB       = 1 << BA_W;
  localparam int BE_W     = DQ_W / 8;
  localparam int AP_BIT   = 10;
  localparam int HOLD_MAX = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                          : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int HW       = $clog2(HOLD_MAX + 1);
  localparam logic [HW-1:0] H_RP  = HW'(T_RP - 1);
  localparam logic [HW-1:0] H_MRD = HW'(T_MRD - 1);
  localparam logic [HW-1:0] H_RC  = HW'(T_RC - 1);
  // burst length 1, sequential, CAS latency in A6..A4
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  ctl_state_e       state_q, state_d;
  logic [HW-1:0]    hold_q, hold_d;
  sd_cmd_e          cmd_q, cmd_d;
  logic [BA_W-1:0]  ba_d;
  logic [ROW_W-1:0] addr_d;
  logic             pall, ref_ack, ref_pend;
  logic [NB-1:0]    act_v, pre_v, wr_v;
  logic [NB-1:0]    bk_open, bk_rw_ok, bk_pre_ok, bk_act_ok;
  logic [ROW_W-1:0] bk_row [NB];
  logic             row_hit;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdc_bank #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
      .T_RP(T_RP), .T_WR(T_WR), .T_DAL(T_DAL)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (act_v[g]),
      .pre_i    (pre_v[g] | pall),
      .wr_i     (wr_v[g]),
      .row_i    (req_row_i),
      .open_o   (bk_open[g]),
      .row_o    (bk_row[g]),
      .rw_ok_o  (bk_rw_ok[g]),
      .pre_ok_o (bk_pre_ok[g]),
      .act_ok_o (bk_act_ok[g])
    );
  end

  sdc_ref_timer #(.REF_CYC(REF_CYC)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (ref_ack),
    .pend_o (ref_pend)
  );

  sdc_rd_pipe #(.CAS_LAT(CAS_LAT), .DQ_W(DQ_W)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_on_pins_i (cmd_q == CMD_RD),
    .dq_i         (sd_dq_i),
    .rdata_o      (rdata_o),
    .rvalid_o     (rvalid_o)
  );

  assign row_hit = bk_open[req_bank_i] && (bk_row[req_bank_i] == req_row_i);

  always_comb begin
    state_d = state_q;
    hold_d  = '0;
    cmd_d   = CMD_NOP;
    ba_d    = '0;
    addr_d  = '0;
    pall    = 1'b0;
    ref_ack = 1'b0;
    ready_o = 1'b0;
    act_v   = '0;
    pre_v   = '0;
    wr_v    = '0;
    if (hold_q != '0) begin
      hold_d = hold_q - 1'b1;
    end else begin
      unique case (state_q)
        ST_PALL: begin
          cmd_d          = CMD_PRE;
          addr_d[AP_BIT] = 1'b1;
          pall           = 1'b1;
          hold_d         = H_RP;
          state_d        = ST_MRS;
        end
        ST_MRS: begin
          cmd_d   = CMD_MRS;
          addr_d  = MODE_WORD;
          hold_d  = H_MRD;
          state_d = ST_RUN;
        end
        default: begin
          if (ref_pend) begin
            // refresh first: close everything, then refresh
            if (|bk_open) begin
              if (&(bk_pre_ok | ~bk_open)) begin
                cmd_d          = CMD_PRE;
                addr_d[AP_BIT] = 1'b1;
                pall           = 1'b1;
              end
            end else if (&bk_act_ok) begin
              cmd_d   = CMD_REF;
              ref_ack = 1'b1;
              hold_d  = H_RC;
            end
          end else if (req_i) begin
            ba_d = req_bank_i;
            if (row_hit) begin
              if (bk_rw_ok[req_bank_i]) begin
                cmd_d                = req_we_i ? CMD_WR : CMD_RD;
                addr_d[COL_W-1:0]    = req_col_i;
                ready_o              = 1'b1;
                wr_v[req_bank_i]     = req_we_i;
              end
            end else if (bk_open[req_bank_i]) begin
              if (bk_pre_ok[req_bank_i]) begin
                cmd_d             = CMD_PRE;
                pre_v[req_bank_i] = 1'b1;
              end
            end else if (bk_act_ok[req_bank_i]) begin
              cmd_d             = CMD_ACT;
              addr_d            = req_row_i;
              act_v[req_bank_i] = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PALL;
      hold_q     <= '0;
      cmd_q      <= CMD_NOP;
      sd_ba_o    <= '0;
      sd_addr_o  <= '0;
      sd_dq_o    <= '0;
      sd_dq_oe_o <= 1'b0;
      sd_dqm_o   <= '0;
    end else begin
      state_q    <= state_d;
      hold_q     <= hold_d;
      cmd_q      <= cmd_d;
      sd_ba_o    <= ba_d;
      sd_addr_o  <= addr_d;
      sd_dq_oe_o <= (cmd_d == CMD_WR);
      sd_dq_o    <= (cmd_d == CMD_WR) ? req_wdata_i : '0;
      sd_dqm_o   <= (cmd_d == CMD_WR) ? ~req_be_i : {BE_W{1'b0}};
    end
  end

  assign {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd_q;
endmodule

// File: rtl/sdc_chk.sv
module sdc_chk
  import sdc_pkg::*;
#(
  parameter int BA_W    = 1,
  parameter int ROW_W   = 11,
  parameter int CAS_LAT = 3,
  parameter int T_RCD   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sd_cs_n_o,
  input logic             sd_ras_n_o,
  input logic             sd_cas_n_o,
  input logic             sd_we_n_o,
  input logic [BA_W-1:0]  sd_ba_o,
  input logic [ROW_W-1:0] sd_addr_o,
  input logic             sd_dq_oe_o,
  input logic             rvalid_o
);
  localparam int NB = 1 << BA_W;

  logic [3:0]    cmd;
  logic [NB-1:0] open_pin;
  logic [7:0]    since_act [NB];

  assign cmd = {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_pin <= '0;
      for (int b = 0; b < NB; b++) since_act[b] <= 8'hff;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (cmd == CMD_ACT && sd_ba_o == BA_W'(b)) since_act[b] <= 8'd1;
        else if (since_act[b] != 8'hff) since_act[b] <= since_act[b] + 8'd1;
      end
      if (cmd == CMD_ACT) open_pin[sd_ba_o] <= 1'b1;
      else if (cmd == CMD_PRE) begin
        if (sd_addr_o[10]) open_pin <= '0;
        else open_pin[sd_ba_o] <= 1'b0;
      end
    end
  end

  p_oe_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_dq_oe_o |-> (cmd == CMD_WR));

  p_mrs_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_MRS) |=> (cmd == CMD_NOP));

  p_ref_closed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_REF) |-> (open_pin == '0));

  p_rvalid_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(cmd == CMD_RD, CAS_LAT + 1));

  p_rcd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_RD || cmd == CMD_WR) |-> (since_act[sd_ba_o] >= 8'(T_RCD)));

  p_act_closed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_ACT) |-> !open_pin[sd_ba_o]);
endmodule

bind sdram_ctl sdc_chk #(
  .BA_W(BA_W), .ROW_W(ROW_W), .CAS_LAT(CAS_LAT), .T_RCD(T_RCD)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sd_cs_n_o  (sd_cs_n_o),
  .sd_ras_n_o (sd_ras_n_o),
  .sd_cas_n_o (sd_cas_n_o),
  .sd_we_n_o  (sd_we_n_o),
  .sd_ba_o    (sd_ba_o),
  .sd_addr_o  (sd_addr_o),
  .sd_dq_oe_o (sd_dq_oe_o),
  .rvalid_o   (rvalid_o)
);

// File: tb/sim_sdram_ctl.sv
`timescale 1ns/1ps
module sim_sdram_ctl;
  localparam int CL      = 3;
  localparam int T_RCD   = 3;
  localparam int T_RAS   = 6;
  localparam int T_RC    = 9;
  localparam int T_RP    = 3;
  localparam int T_MRD   = 2;
  localparam int T_WR    = 2;
  localparam int T_DAL   = 4;
  localparam int REF_CYC = 150;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [0:0]  req_bank = '0;
  logic [10:0] req_row = '0;
  logic [7:0]  req_col = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        ready, rvalid;
  logic [15:0] rdata;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [0:0]  ba;
  logic [10:0] addr;
  logic [1:0]  dqm;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic [15:0] dq_in = 16'hbad0;

  always #2.5 clk = ~clk;

  sdram_ctl #(.CAS_LAT(CL), .REF_CYC(REF_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(req_we),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .req_wdata_i(req_wdata), .req_be_i(req_be), .ready_o(ready),
    .rdata_o(rdata), .rvalid_o(rvalid), .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n),
    .sd_cas_n_o(cas_n), .sd_we_n_o(we_n), .sd_ba_o(ba), .sd_addr_o(addr),
    .sd_dqm_o(dqm), .sd_dq_o(dq_out), .sd_dq_oe_o(dq_oe), .sd_dq_i(dq_in)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // pin-level memory model and timing bookkeeping
  int cyc = 0;
  int last_act[2] = '{-1000, -1000};
  int last_pre[2] = '{-1000, -1000};
  int last_wr[2]  = '{-1000, -1000};
  int last_ref = -1000, last_mrs = -1000, first_ref_ok = 0;
  int run_start = 0, ref_count = 0, ncmd = 0;
  bit open_m[2];
  int row_m[2];
  logic [15:0] smem [int];
  logic [15:0] umem [int];
  logic [15:0] rd_data_q[$];
  int rd_due_q[$];
  int rd_t_q[$];
  logic [15:0] exp_q[$];

  function automatic int key(input int b, input int r, input int c);
    return (b << 19) | (r << 8) | c;
  endfunction

  always @(negedge clk) begin
    logic [3:0] cmd;
    int b, k;
    cyc++;
    cmd = {cs_n, ras_n, cas_n, we_n};
    b = int'(ba);
    if (!rst_n) begin
      chk(cmd == 4'b0111 && !ready && !rvalid && !dq_oe, "R1 reset idle", int'(cmd), 7);
    end else begin
      if (cmd != 4'b0111) begin
        ncmd++;
        if (ncmd == 1) chk(cmd == 4'b0010 && addr[10], "R1 first precharge-all", int'(cmd), 2);
        if (ncmd == 2) chk(cmd == 4'b0000, "R1 second is mode set", int'(cmd), 0);
        chk(cyc - last_mrs >= T_MRD, "R3 mode set gap", cyc - last_mrs, T_MRD);
        chk(cyc - last_ref >= T_RC, "R6 refresh to next", cyc - last_ref, T_RC);
      end
      chk(!dq_oe || cmd == 4'b0100, "R7 oe only on write", int'(dq_oe), 0);
      case (cmd)
        4'b0111: ;
        4'b0000: begin
          chk(addr == 11'(CL << 4), "R2 mode word", int'(addr), CL << 4);
          chk(!open_m[0] && !open_m[1], "R2 mode set with banks closed", int'(open_m[0]), 0);
          last_mrs = cyc;
          run_start = cyc;
        end
        4'b0011: begin
          chk(!open_m[b], "R10 activate closed bank", int'(open_m[b]), 0);
          chk(cyc - last_act[b] >= T_RC, "R5 tRC", cyc - last_act[b], T_RC);
          chk(cyc - last_pre[b] >= T_RP, "R6 tRP", cyc - last_pre[b], T_RP);
          chk(cyc - last_wr[b] >= T_DAL, "R8 write to activate", cyc - last_wr[b], T_DAL);
          open_m[b] = 1; row_m[b] = int'(addr); last_act[b] = cyc;
        end
        4'b0101, 4'b0100: begin
          chk(open_m[b], "R10 column command to open bank", int'(open_m[b]), 1);
          chk(cyc - last_act[b] >= T_RCD, "R4 tRCD", cyc - last_act[b], T_RCD);
          chk(!addr[10], "R10 A10 low on column command", int'(addr[10]), 0);
          k = key(b, row_m[b], int'(addr[7:0]));
          if (cmd == 4'b0100) begin
            logic [15:0] old;
            chk(dq_oe, "R7 data with write", int'(dq_oe), 1);
            old = smem.exists(k) ? smem[k] : 16'h0;
            if (!dqm[0]) old[7:0]  = dq_out[7:0];
            if (!dqm[1]) old[15:8] = dq_out[15:8];
            smem[k] = old;
            last_wr[b] = cyc;
          end else begin
            rd_data_q.push_back(smem.exists(k) ? smem[k] : 16'h0);
            rd_due_q.push_back(cyc + CL);
            rd_t_q.push_back(cyc);
          end
        end
        4'b0010: begin
          for (int i = 0; i < 2; i++) begin
            if (addr[10] || i == b) begin
              if (!addr[10]) chk(open_m[i], "R10 single precharge of open bank", int'(open_m[i]), 1);
              if (open_m[i]) begin
                chk(cyc - last_act[i] >= T_RAS, "R5 tRAS", cyc - last_act[i], T_RAS);
                chk(cyc - last_wr[i] >= T_WR, "R8 write to precharge", cyc - last_wr[i], T_WR);
              end
              open_m[i] = 0; last_pre[i] = cyc;
            end
          end
        end
        4'b0001: begin
          chk(!open_m[0] && !open_m[1], "R11 refresh with banks closed", int'(open_m[0]) + int'(open_m[1]), 0);
          chk(cyc - last_pre[0] >= T_RP && cyc - last_pre[1] >= T_RP, "R11 tRP before refresh",
              cyc - last_pre[0], T_RP);
          if (ref_count > 0)
            chk(cyc - last_ref <= REF_CYC + 40, "R11 refresh interval", cyc - last_ref, REF_CYC + 40);
          ref_count++; last_ref = cyc;
        end
        default: chk(0, "R2 unknown command code", int'(cmd), 7);
      endcase
      // refresh must not go missing for longer than the interval
      if (run_start > 0 && cyc - ((ref_count > 0) ? last_ref : 0) > REF_CYC + 40 && first_ref_ok == 0) begin
        chk(0, "R11 refresh overdue", cyc - last_ref, REF_CYC + 40);
        first_ref_ok = 1;
      end
      // user side
      if (rvalid) begin
        int t;
        chk(rd_t_q.size() > 0, "R9 rvalid with a read", rd_t_q.size(), 1);
        if (rd_t_q.size() > 0) begin
          t = rd_t_q.pop_front();
          chk(cyc == t + CL + 1, "R9 read latency", cyc - t, CL + 1);
        end
        chk(exp_q.size() > 0, "R12 result for a request", exp_q.size(), 1);
        if (exp_q.size() > 0) begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rdata === e, "R9 R12 read data", int'(rdata), int'(e));
        end
      end
      if (req && ready) begin
        k = key(int'(req_bank), int'(req_row), int'(req_col));
        if (req_we) begin
          logic [15:0] old;
          old = umem.exists(k) ? umem[k] : 16'h0;
          if (req_be[0]) old[7:0]  = req_wdata[7:0];
          if (req_be[1]) old[15:8] = req_wdata[15:8];
          umem[k] = old;
        end else begin
          exp_q.push_back(umem.exists(k) ? umem[k] : 16'h0);
        end
      end
    end
    // memory drives read data to be stable at the capture edge
    if (rd_due_q.size() > 0 && rd_due_q[0] == cyc) begin
      void'(rd_due_q.pop_front());
      dq_in = rd_data_q.pop_front();
    end else begin
      dq_in = 16'hbad0;
    end
  end

  task automatic do_req(input bit we, input int b, input int r, input int c,
                        input logic [15:0] d, input logic [1:0] be);
    @(posedge clk); #1;
    req = 1; req_we = we; req_bank = 1'(b); req_row = 11'(r);
    req_col = 8'(c); req_wdata = d; req_be = be;
    forever begin
      @(negedge clk);
      if (ready) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R10 row hits in bank 0
    for (int i = 0; i < 4; i++) do_req(1, 0, 5, i, 16'h1000 + 16'(i), 2'b11);
    for (int i = 0; i < 4; i++) do_req(0, 0, 5, i, 16'h0, 2'b11);
    // R7 byte enables merge
    do_req(1, 0, 5, 1, 16'habcd, 2'b01);
    do_req(1, 0, 5, 2, 16'hef12, 2'b10);
    do_req(0, 0, 5, 1, 0, 2'b11);
    do_req(0, 0, 5, 2, 0, 2'b11);
    // R5 R6 R8 row misses in one bank, extreme addresses
    do_req(1, 0, 2047, 255, 16'h7777, 2'b11);
    do_req(0, 0, 5, 3, 0, 2'b11);
    do_req(0, 0, 2047, 255, 0, 2'b11);
    // independent banks
    for (int i = 0; i < 6; i++) do_req(i % 2 == 0, i % 2, 9, 7, 16'h5a00 + 16'(i), 2'b11);
    do_req(0, 0, 9, 7, 0, 2'b11);
    do_req(0, 1, 9, 7, 0, 2'b11);
    // pseudo-random mix with refreshes interleaved (R11 R12)
    seed = 32'h1d2c3b4a;
    for (int i = 0; i < 400; i++) begin
      int rows[3] = '{3, 500, 2047};
      seed = seed * 1103515245 + 12345;
      do_req(seed[16], int'(seed[17]), rows[(seed >>> 20) & 3 % 3 > 2 ? 0 : ((seed >>> 20) & 3) % 3],
             int'(seed[11:8]) * 17 % 256, 16'(seed >>> 3), (seed[25:24] == 2'b00) ? 2'b11 : seed[25:24]);
    end
    @(posedge clk); #1; req = 0;
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R12 every read answered", exp_q.size(), 0);
    chk(rd_t_q.size() == 0, "R9 every read returned", rd_t_q.size(), 0);
    chk(ref_count >= (cyc - run_start) / (REF_CYC + 40), "R11 refresh count",
        ref_count, (cyc - run_start) / (REF_CYC + 40));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule